// File: doc/BRIEF.md
# Rotating Iteration-Frame Register File

This block holds the operand registers of a loop-oriented processor with six functional units. There are seven banks of 64 words: one private bank per functional unit and one general bank shared by all units. Every register name is an offset from an iteration base rather than a fixed location. Each pulse of the iteration-advance strobe steps that base down by one. A value written under name `r` in one iteration therefore shows up as `r+1` in the next. Each iteration works in a fresh frame, and results from earlier iterations stay readable until the base wraps around.

Two read ports take 9-bit source names. Each functional unit has one write port that takes a 7-bit destination name. A separate file of 128 one-bit predicates rotates together with the operand base. Every write must name a predicate, and the write lands only when that predicate bit is set. Predicates are loaded through their own set port.

Top module: `rotRegFile`

## Requirements
- R1: A synchronous reset sets the iteration base to zero and clears every predicate bit. Register contents survive reset. After reset, any write that names a predicate leaves its target unchanged until that predicate is set again.
- R2: A source name is 9 bits. Bits [8:6] select the bank: codes 0..5 are the private banks of units 0..5 and code 6 is the general bank. Bits [5:0] give the register index. The read is combinational.
- R3: A destination name is 7 bits. Bit 6 = 1 targets the general bank and bit 6 = 0 targets the writing unit's own bank. Bits [5:0] give the index.
- R4: The physical location is (index + base) mod 64. One advance pulse lowers the base by one, so a value written as `r` reads as `(r+1) mod 64` afterwards. After 64 pulses the original mapping returns.
- R5: A unit's write takes effect only when its valid bit is high and the predicate at (predicate name + predicate base) mod 128 is 1.
- R6: The predicate base moves with the operand base, modulo 128. A predicate set under name `p` is found under `(p+1) mod 128` after one advance. The set port uses the current base.
- R7: A read of a location that is being written in the same cycle returns the old value. The new value is visible from the next cycle on.
- R8: Bank code 7 is reserved. Reading it returns zero and raises that port's error flag. Every other code leaves the flag low.
- R9: When several units write the general bank in the same cycle, only the lowest-numbered unit's write takes effect.
- R10: All six units can write their own banks in the same cycle. A write to one bank never changes the same index in another bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| iterAdvance | input | 1 | Step to the next iteration frame |
| predSetEn | input | 1 | Load a predicate bit |
| predSetIdx | input | 7 | Predicate name to load |
| predSetVal | input | 1 | Value to load |
| wrValid | input | 6 | Per-unit write request |
| wrSpec | input | 42 | Per-unit 7-bit destination name, unit i at [7i+6:7i] |
| wrPred | input | 42 | Per-unit 7-bit predicate name, unit i at [7i+6:7i] |
| wrData | input | 192 | Per-unit write data, unit i at [32i+31:32i] |
| rdSpecA | input | 9 | Source name, read port A |
| rdSpecB | input | 9 | Source name, read port B |
| rdDataA | output | 32 | Read data, port A |
| rdDataB | output | 32 | Read data, port B |
| rdErrA | output | 1 | Reserved bank code on port A |
| rdErrB | output | 1 | Reserved bank code on port B |

## Verification
The assertions assume that reset is held for at least one clock edge before any check counts. They also assume that the operand base and the predicate base leave reset together and are moved only by the advance strobe. The bench respects both: it drives every input on the falling edge, applies a reset at the start of each scenario, and never pulses advance during reset. Predicate bits are set explicitly before each write that is meant to land. A write that is meant to be dropped is always preceded by a known value at the same location, so reading that location back shows whether the write was dropped.

// File: rtl/rotRfPkg.sv
package rotRfPkg;
  localparam int NUM_FU     = 6;
  localparam int NUM_BANKS  = NUM_FU + 1;
  localparam int GEN_BANK   = NUM_FU;
  localparam int IDX_W      = 6;
  localparam int BANK_DEPTH = 1 << IDX_W;
  localparam int SEL_W      = 3;
  localparam int SRC_W      = SEL_W + IDX_W;
  localparam int DST_W      = IDX_W + 1;
  localparam int PRED_W     = 7;
  localparam int PRED_DEPTH = 1 << PRED_W;
  localparam int DFLT_DATA_W = 32;

  // strobes from control to datapath, one lane per functional unit
  typedef struct packed {
    logic [NUM_FU-1:0]            wrEn;
    logic [NUM_FU-1:0]            toGen;
    logic [NUM_FU-1:0][IDX_W-1:0] wrPhys;
    logic [IDX_W-1:0]             base;
  } rfStrobes_t;
endpackage

// File: rtl/rotCtrl.sv
module rotCtrl
  import rotRfPkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    iterAdvance,
  input  logic                    predSetEn,
  input  logic [PRED_W-1:0]       predSetIdx,
  input  logic                    predSetVal,
  input  logic [NUM_FU-1:0]       wrValid,
  input  logic [NUM_FU*DST_W-1:0] wrSpec,
  input  logic [NUM_FU*PRED_W-1:0] wrPred,
  output rfStrobes_t              strb
);
  logic [IDX_W-1:0]      opBase;
  logic [PRED_W-1:0]     predBase;
  logic [PRED_DEPTH-1:0] predBits;
  logic [PRED_W-1:0]     predSetPhys;

  logic [NUM_FU-1:0]            wrEnV;
  logic [NUM_FU-1:0]            toGenV;
  logic [NUM_FU-1:0][IDX_W-1:0] physV;

  always_comb predSetPhys = predSetIdx + predBase;

  always_ff @(posedge clk) begin
    if (rst) begin
      opBase   <= '0;
      predBase <= '0;
      predBits <= '0;
    end else begin
      if (iterAdvance) begin
        opBase   <= opBase - 1'b1;
        predBase <= predBase - 1'b1;
      end
      if (predSetEn) predBits[predSetPhys] <= predSetVal;
    end
  end

  for (genvar i = 0; i < NUM_FU; i++) begin : g_lane
    logic [DST_W-1:0]  spec;
    logic [PRED_W-1:0] predPhys;
    assign spec     = wrSpec[i*DST_W +: DST_W];
    assign predPhys = wrPred[i*PRED_W +: PRED_W] + predBase;
    assign wrEnV[i]  = wrValid[i] & predBits[predPhys];
    assign toGenV[i] = spec[DST_W-1];
    assign physV[i]  = spec[IDX_W-1:0] + opBase;
  end

  assign strb = '{wrEn: wrEnV, toGen: toGenV, wrPhys: physV, base: opBase};

  AST_BASE_STEP: assert property (@(posedge clk) disable iff (rst)
    iterAdvance |=> opBase == $past(opBase) - 1'b1); // R4
  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !iterAdvance |=> $stable(opBase)); // R4
  AST_PRED_ALIGN: assert property (@(posedge clk) disable iff (rst)
    predBase[IDX_W-1:0] == opBase); // R6
  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (predBits == '0 && opBase == '0 && predBase == '0)); // R1
endmodule

// File: rtl/rotDatapath.sv
module rotDatapath
  import rotRfPkg::*;
#(
  parameter int DATA_W = DFLT_DATA_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  rfStrobes_t               strb,
  input  logic [NUM_FU*DATA_W-1:0] wrData,
  input  logic [SRC_W-1:0]         rdSpecA,
  input  logic [SRC_W-1:0]         rdSpecB,
  output logic [DATA_W-1:0]        rdDataA,
  output logic [DATA_W-1:0]        rdDataB,
  output logic                     rdErrA,
  output logic                     rdErrB
);
  logic [NUM_FU-1:0] genGrant;
  logic [IDX_W-1:0]  genPhys;
  logic [DATA_W-1:0] genData;
  logic [IDX_W-1:0]  physA, physB;
  logic [SEL_W-1:0]  selA, selB;
  logic [DATA_W-1:0] bankRdA [NUM_BANKS];
  logic [DATA_W-1:0] bankRdB [NUM_BANKS];

  // lowest unit index wins the shared bank
  always_comb begin
    genGrant = '0;
    genPhys  = '0;
    genData  = '0;
    for (int i = NUM_FU - 1; i >= 0; i--) begin
      if (strb.wrEn[i] && strb.toGen[i]) begin
        genGrant    = '0;
        genGrant[i] = 1'b1;
        genPhys     = strb.wrPhys[i];
        genData     = wrData[i*DATA_W +: DATA_W];
      end
    end
  end

  assign physA = rdSpecA[IDX_W-1:0] + strb.base;
  assign physB = rdSpecB[IDX_W-1:0] + strb.base;
  assign selA  = rdSpecA[SRC_W-1:IDX_W];
  assign selB  = rdSpecB[SRC_W-1:IDX_W];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] cells [BANK_DEPTH];
    logic              we;
    logic [IDX_W-1:0]  wa;
    logic [DATA_W-1:0] wd;
    if (b < NUM_FU) begin : g_own
      assign we = strb.wrEn[b] & ~strb.toGen[b];
      assign wa = strb.wrPhys[b];
      assign wd = wrData[b*DATA_W +: DATA_W];
    end else begin : g_shared
      assign we = |genGrant;
      assign wa = genPhys;
      assign wd = genData;
    end
    always_ff @(posedge clk) begin
      if (we) cells[wa] <= wd;
    end
    assign bankRdA[b] = cells[physA];
    assign bankRdB[b] = cells[physB];
  end

  always_comb begin
    rdErrA  = 1'b1;
    rdDataA = '0;
    if (int'(selA) < NUM_BANKS) begin
      rdErrA  = 1'b0;
      rdDataA = bankRdA[selA];
    end
    rdErrB  = 1'b1;
    rdDataB = '0;
    if (int'(selB) < NUM_BANKS) begin
      rdErrB  = 1'b0;
      rdDataB = bankRdB[selB];
    end
  end

  AST_RSVD_ZERO_A: assert property (@(posedge clk) disable iff (rst)
    rdErrA |-> rdDataA == '0); // R8
  AST_RSVD_ZERO_B: assert property (@(posedge clk) disable iff (rst)
    rdErrB |-> rdDataB == '0); // R8
  AST_GEN_SINGLE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(genGrant)); // R9
endmodule

// File: rtl/rotRegFile.sv
module rotRegFile
  import rotRfPkg::*;
#(
  parameter int DATA_W = DFLT_DATA_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      iterAdvance,
  input  logic                      predSetEn,
  input  logic [PRED_W-1:0]         predSetIdx,
  input  logic                      predSetVal,
  input  logic [NUM_FU-1:0]         wrValid,
  input  logic [NUM_FU*DST_W-1:0]   wrSpec,
  input  logic [NUM_FU*PRED_W-1:0]  wrPred,
  input  logic [NUM_FU*DATA_W-1:0]  wrData,
  input  logic [SRC_W-1:0]          rdSpecA,
  input  logic [SRC_W-1:0]          rdSpecB,
  output logic [DATA_W-1:0]         rdDataA,
  output logic [DATA_W-1:0]         rdDataB,
  output logic                      rdErrA,
  output logic                      rdErrB
);
  rfStrobes_t strb;

  rotCtrl u_ctrl (
    .clk(clk), .rst(rst), .iterAdvance(iterAdvance),
    .predSetEn(predSetEn), .predSetIdx(predSetIdx), .predSetVal(predSetVal),
    .wrValid(wrValid), .wrSpec(wrSpec), .wrPred(wrPred), .strb(strb)
  );

  rotDatapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .wrData(wrData),
    .rdSpecA(rdSpecA), .rdSpecB(rdSpecB),
    .rdDataA(rdDataA), .rdDataB(rdDataB),
    .rdErrA(rdErrA), .rdErrB(rdErrB)
  );
endmodule

// File: tb/rotRegFile_tb.sv
module rotRegFile_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         iterAdvance = 1'b0;
  logic         predSetEn = 1'b0;
  logic [6:0]   predSetIdx = '0;
  logic         predSetVal = 1'b0;
  logic [5:0]   wrValid = '0;
  logic [41:0]  wrSpec = '0;
  logic [41:0]  wrPred = '0;
  logic [191:0] wrData = '0;
  logic [8:0]   rdSpecA = '0;
  logic [8:0]   rdSpecB = '0;
  logic [31:0]  rdDataA, rdDataB;
  logic         rdErrA, rdErrB;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  rotRegFile u_dut (.*);

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  function automatic logic [8:0] src(int b, int i);
    return {b[2:0], i[5:0]};
  endfunction

  task automatic chkRead(string tag, logic [8:0] spec, logic [31:0] expD, logic expE);
    rdSpecA = spec;
    rdSpecB = spec;
    #1;
    nChecks++;
    if (rdDataA !== expD || rdErrA !== expE || rdDataB !== expD || rdErrB !== expE) begin
      nFails++;
      $display("FAIL %s: spec %h actual A=%h/%b B=%h/%b expected %h/%b",
               tag, spec, rdDataA, rdErrA, rdDataB, rdErrB, expD, expE);
    end
  endtask

  task automatic clearWr();
    wrValid = '0; wrSpec = '0; wrPred = '0; wrData = '0;
  endtask

  task automatic resetDut();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic setPred(logic [6:0] idx, logic val);
    @(negedge clk); predSetEn = 1'b1; predSetIdx = idx; predSetVal = val;
    @(negedge clk); predSetEn = 1'b0;
  endtask

  task automatic advance(int n);
    @(negedge clk); iterAdvance = 1'b1;
    repeat (n) @(negedge clk);
    iterAdvance = 1'b0;
  endtask

  task automatic doWrite(int fu, logic [6:0] dst, logic [6:0] p, logic [31:0] d, logic v = 1'b1);
    @(negedge clk);
    wrValid[fu] = v;
    wrSpec[fu*7 +: 7] = dst;
    wrPred[fu*7 +: 7] = p;
    wrData[fu*32 +: 32] = d;
    @(negedge clk);
    clearWr();
  endtask

  // R1: reset zeroes base and clears predicates, keeps data
  task automatic testReset();
    resetDut();
    setPred(7'd0, 1'b1);
    doWrite(0, 7'd0, 7'd0, 32'hA1A1_0001);
    advance(3);
    resetDut();
    doWrite(0, 7'd0, 7'd0, 32'hB2B2_0002);
    chkRead("R1 reset base and predicate", src(0, 0), 32'hA1A1_0001, 1'b0);
  endtask

  // R2 R3 R10: decode, all units at once, own vs general
  task automatic testDecode();
    resetDut();
    setPred(7'd0, 1'b1);
    doWrite(2, {1'b0, 6'd5}, 7'd0, 32'h0000_0222);
    @(negedge clk);
    for (int fu = 0; fu < 6; fu++) begin
      wrValid[fu] = 1'b1;
      wrSpec[fu*7 +: 7] = {1'b0, 6'd10};
      wrData[fu*32 +: 32] = 32'h100 + fu;
    end
    @(negedge clk);
    clearWr();
    for (int fu = 0; fu < 6; fu++)
      chkRead("R10 R2 parallel own-bank writes", src(fu, 10), 32'h100 + fu, 1'b0);
    doWrite(2, {1'b1, 6'd5}, 7'd0, 32'h0000_0AAA);
    chkRead("R3 general bank target", src(6, 5), 32'h0000_0AAA, 1'b0);
    chkRead("R3 own bank untouched", src(2, 5), 32'h0000_0222, 1'b0);
  endtask

  // R4: frame rotation and wrap
  task automatic testRotate();
    resetDut();
    setPred(7'd0, 1'b1);
    doWrite(0, 7'd7, 7'd0, 32'hD1);
    advance(1);
    chkRead("R4 old value moves to r+1", src(0, 8), 32'hD1, 1'b0);
    setPred(7'd0, 1'b1);
    doWrite(0, 7'd7, 7'd0, 32'hD2);
    chkRead("R4 new frame value", src(0, 7), 32'hD2, 1'b0);
    chkRead("R4 previous frame intact", src(0, 8), 32'hD1, 1'b0);
    resetDut();
    setPred(7'd0, 1'b1);
    doWrite(1, 7'd63, 7'd0, 32'hD3);
    advance(1);
    chkRead("R4 index wraps 63 to 0", src(1, 0), 32'hD3, 1'b0);
    advance(63);
    chkRead("R4 full 64-step cycle", src(1, 63), 32'hD3, 1'b0);
  endtask

  // R5 R6: predicate gating and rotation
  task automatic testPredicate();
    resetDut();
    setPred(7'd9, 1'b1);
    doWrite(3, 7'd20, 7'd9, 32'h5555);
    setPred(7'd9, 1'b0);
    doWrite(3, 7'd20, 7'd9, 32'h6666);
    chkRead("R5 cleared predicate blocks write", src(3, 20), 32'h5555, 1'b0);
    setPred(7'd9, 1'b1);
    doWrite(3, 7'd20, 7'd9, 32'h7777, 1'b0);
    chkRead("R5 invalid write ignored", src(3, 20), 32'h5555, 1'b0);
    resetDut();
    setPred(7'd5, 1'b1);
    advance(1);
    doWrite(4, 7'd20, 7'd6, 32'h0F0F);
    chkRead("R6 predicate moved to p+1", src(4, 20), 32'h0F0F, 1'b0);
    doWrite(4, 7'd20, 7'd5, 32'hBAD0);
    chkRead("R6 old predicate name now clear", src(4, 20), 32'h0F0F, 1'b0);
    resetDut();
    setPred(7'd127, 1'b1);
    advance(1);
    doWrite(5, 7'd30, 7'd0, 32'h7F00);
    chkRead("R6 predicate wraps 127 to 0", src(5, 30), 32'h7F00, 1'b0);
  endtask

  // R7: read during write sees old value
  task automatic testReadDuringWrite();
    resetDut();
    setPred(7'd0, 1'b1);
    doWrite(0, 7'd40, 7'd0, 32'h0001);
    @(negedge clk);
    wrValid[0] = 1'b1; wrSpec[6:0] = 7'd40; wrPred[6:0] = 7'd0; wrData[31:0] = 32'h0002;
    chkRead("R7 same-cycle read returns old", src(0, 40), 32'h0001, 1'b0);
    @(negedge clk);
    clearWr();
    chkRead("R7 new value next cycle", src(0, 40), 32'h0002, 1'b0);
  endtask

  // R8: reserved bank code
  task automatic testReserved();
    chkRead("R8 reserved code reads zero with error", src(7, 3), 32'h0, 1'b1);
    rdSpecA = src(7, 40);
    rdSpecB = src(0, 40);
    #1;
    nChecks++;
    if (rdErrA !== 1'b1 || rdDataA !== 32'h0 || rdErrB !== 1'b0 || rdDataB !== 32'h0002) begin
      nFails++;
      $display("FAIL R8 mixed ports: actual A=%h/%b B=%h/%b expected 0/1 00000002/0",
               rdDataA, rdErrA, rdDataB, rdErrB);
    end
  endtask

  // R9: general-bank conflict
  task automatic testPriority();
    resetDut();
    setPred(7'd0, 1'b1);
    @(negedge clk);
    wrValid = 6'b010010;
    wrSpec[1*7 +: 7] = {1'b1, 6'd50};
    wrSpec[4*7 +: 7] = {1'b1, 6'd50};
    wrData[1*32 +: 32] = 32'h1111;
    wrData[4*32 +: 32] = 32'h4444;
    @(negedge clk);
    clearWr();
    chkRead("R9 lowest unit wins general bank", src(6, 50), 32'h1111, 1'b0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    testReset();
    testDecode();
    testRotate();
    testPredicate();
    testReadDuringWrite();
    testReserved();
    testPriority();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule